// File: doc/BRIEF.md
# Write-Forwarding Dual-Port RAM

This block is a single-clock memory with one write port and one synchronous read port. The storage array underneath returns the previously stored word when a read and a write land on the same address in the same cycle. A small forwarding stage sits on top of the array so that the read port returns the freshly written bytes in that case instead. The read result appears one clock after the read is presented.

Writes carry one enable per byte lane. When a collision happens, only the lanes being written come from the write data; the other lanes come from the array. The read port has its own enable. While that enable is low, the read output keeps its last value, even if a write hits the address being presented on the read side. The forwarding state is captured only on enabled reads, so a disabled read never sees the write.

Top module: `fwd_ram_top`

## Requirements
- R1: While reset is asserted and after it is released, `rdData` reads zero until the first enabled read.
- R2: A read with `rdEn` high at a clock edge, with no write to the same address, shows the word stored at `rdAddr` on `rdData` after that edge.
- R3: When all byte enables are set and `wrAddr` equals `rdAddr` with `rdEn` high, `rdData` after that edge equals `wrData`.
- R4: On a collision with partial byte enables, lane i of `rdData` (bits i*BYTE_W upward) comes from `wrData` when `wrBe[i]` is set and from the previously stored word otherwise.
- R5: While `rdEn` is low at an edge, `rdData` keeps its value, including when a write targets the presented read address.
- R6: A write stores only the lanes whose `wrBe` bit is set; other lanes of that word keep their old contents, as seen by a later read.
- R7: A write to an address other than `rdAddr` does not change the value returned by that cycle's read.
- R8: A write that collided with a disabled read is still stored, and a later enabled read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrBe | input | DATA_W/BYTE_W | Per-lane write enables; lane i is bits i*BYTE_W upward |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read enable; low holds `rdData` |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Read data, one cycle after an enabled read |

## Verification
A wrong forwarding register shows up on `rdData` on the very cycle after the faulty capture: a lane that should have been forwarded returns the old array byte, or a held output changes during a disabled collision. A wrong array write only appears later, when that address is read again, so the bench sweeps every address and every byte-enable pattern through collisions with the read enable both high and low, then reads the whole array back.

// File: rtl/fwd_ram_pkg.sv
package fwd_ram_pkg;
  typedef struct packed {
    logic capture;
    logic addrHit;
    logic anyWrite;
  } fwdStrobe_t;
endpackage

// File: rtl/fwd_ram_ctrl.sv
module fwd_ram_ctrl
  import fwd_ram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2
) (
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [LANES-1:0]  wrBe,
  output fwdStrobe_t        strb,
  output logic [LANES-1:0]  hitVec
);
  always_comb begin
    strb.capture  = rdEn;
    strb.addrHit  = (wrAddr == rdAddr);
    strb.anyWrite = |wrBe;
    hitVec        = strb.addrHit ? wrBe : '0;
  end
endmodule

// File: rtl/fwd_ram_data.sv
module fwd_ram_data
  import fwd_ram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fwdStrobe_t        strb,
  input  logic [DATA_W/BYTE_W-1:0] hitVec,
  input  logic [DATA_W/BYTE_W-1:0] wrBe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int LANES = DATA_W / BYTE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ramQ;
  logic [DATA_W-1:0] fwdData;
  logic [LANES-1:0]  fwdHit;

  // Array write, lane by lane
  always_ff @(posedge clk) begin
    if (strb.anyWrite) begin
      for (int i = 0; i < LANES; i++) begin
        if (wrBe[i]) mem[wrAddr][i*BYTE_W +: BYTE_W] <= wrData[i*BYTE_W +: BYTE_W];
      end
    end
  end

  // Read-before-write array output, gated by the read enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ramQ <= '0;
    else if (strb.capture)  ramQ <= mem[rdAddr];
  end

  // Forwarding registers, gated by the same enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdData <= '0;
      fwdHit  <= '0;
    end else if (strb.capture) begin
      fwdData <= wrData;
      fwdHit  <= hitVec;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign rdData[g*BYTE_W +: BYTE_W] =
      fwdHit[g] ? fwdData[g*BYTE_W +: BYTE_W] : ramQ[g*BYTE_W +: BYTE_W];

    // R4: a forwarded lane carries the written byte
    a_r4_lane_fwd: assert property (@(posedge clk) disable iff (!rstN)
      (strb.capture && hitVec[g]) |=>
        rdData[g*BYTE_W +: BYTE_W] == $past(wrData[g*BYTE_W +: BYTE_W]));
  end

  a_r3_full_collision: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && strb.addrHit && (&wrBe)) |=> rdData == $past(wrData));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(rdData));

  a_r7_no_forward: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.addrHit) |=> rdData == ramQ);
endmodule

// File: rtl/fwd_ram_top.sv
module fwd_ram_top
  import fwd_ram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [DATA_W/BYTE_W-1:0] wrBe,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     rdEn,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic [DATA_W-1:0]        rdData
);
  localparam int LANES = DATA_W / BYTE_W;

  initial begin
    if (DATA_W % BYTE_W != 0) $error("DATA_W must be a multiple of BYTE_W");
  end

  fwdStrobe_t       strb;
  logic [LANES-1:0] hitVec;

  fwd_ram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .rdEn(rdEn), .wrAddr(wrAddr), .rdAddr(rdAddr), .wrBe(wrBe),
    .strb(strb), .hitVec(hitVec)
  );

  fwd_ram_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .hitVec(hitVec), .wrBe(wrBe),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/fwd_ram_top_tb.sv
module fwd_ram_top_tb;
  localparam int AW = 4, DW = 16, BW = 8, NB = DW / BW, DEPTH = 1 << AW;

  logic clk = 1'b0, rstN = 1'b0;
  logic [NB-1:0] wrBe = '0;
  logic [AW-1:0] wrAddr = '0, rdAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [DW-1:0] rdData;

  int runs = 0, fails = 0;
  logic [DW-1:0] refMem [DEPTH];
  logic [DW-1:0] held = '0;

  always #10 clk = ~clk;

  fwd_ram_top #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BW)) u_dut (
    .clk(clk), .rstN(rstN), .wrBe(wrBe), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic logic [DW-1:0] pat(int a, int k);
    return 16'(a * 16'h1357 + k * 16'h0f0f + 16'h2468);
  endfunction

  task automatic check(string tag, logic [DW-1:0] exp);
    runs++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s: rdData=%h expected=%h", tag, rdData, exp);
    end
  endtask

  task automatic step(logic [NB-1:0] be, int wa, logic [DW-1:0] wd,
                      logic re, int ra, string tag, logic doCheck);
    @(negedge clk);
    wrBe = be; wrAddr = AW'(wa); wrData = wd; rdEn = re; rdAddr = AW'(ra);
    @(posedge clk);
    if (re) begin
      for (int i = 0; i < NB; i++)
        held[i*BW +: BW] = (be[i] && wa == ra) ? wd[i*BW +: BW] : refMem[ra][i*BW +: BW];
    end
    for (int i = 0; i < NB; i++)
      if (be[i]) refMem[wa][i*BW +: BW] = wd[i*BW +: BW];
    @(negedge clk);
    if (doCheck) check(tag, held);
  endtask

  initial begin
    #(200000 * 20);
    runs++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) refMem[a] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", '0);

    // Fill with rdEn low: output must stay zero (R5)
    for (int a = 0; a < DEPTH; a++) step('1, a, pat(a, 0), 1'b0, a, "R5", 1'b1);

    // Plain reads of every address (R2)
    for (int a = 0; a < DEPTH; a++) step('0, 0, '0, 1'b1, a, "R2", 1'b1);

    // Collisions, every byte-enable pattern, read enabled (R3, R4)
    for (int a = 0; a < DEPTH; a++)
      for (int be = 0; be < (1 << NB); be++)
        step(NB'(be), a, pat(a, be + 1), 1'b1, a, (be == (1 << NB) - 1) ? "R3" : "R4", 1'b1);

    // Collisions with read disabled: output holds (R5); then read back (R8)
    for (int a = 0; a < DEPTH; a++) begin
      step('0, 0, '0, 1'b1, (a + 1) % DEPTH, "R2", 1'b1);
      for (int be = 1; be < (1 << NB); be++)
        step(NB'(be), a, pat(a, be + 7), 1'b0, a, "R5", 1'b1);
      step('0, 0, '0, 1'b1, a, "R8", 1'b1);
    end

    // Writes elsewhere while reading (R7)
    for (int a = 0; a < DEPTH; a++)
      step('1, (a + 3) % DEPTH, pat(a, 20), 1'b1, a, "R7", 1'b1);

    // Partial writes without collision, then read back (R6)
    for (int a = 0; a < DEPTH; a++)
      step(NB'(1 + (a % NB)), a, pat(a, 30), 1'b1, (a + 5) % DEPTH, "R7", 1'b1);
    for (int a = 0; a < DEPTH; a++) step('0, 0, '0, 1'b1, a, "R6", 1'b1);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule